// File: doc/BRIEF.md
# Dual-Channel Compare Match Timer

This peripheral holds two independent 16-bit up-counters fed from one input clock. Each channel divides that clock by a selectable power-of-four ratio. On each divided tick the channel's counter steps upward. When the counter has reached its compare value, the next tick returns it to zero and may raise a one-cycle interrupt pulse on that channel's own output. A shared start register gates each channel. Setting a channel's start bit clears its counter and its divider phase, so the first match comes a full period after the start.

Software reaches the block through a plain 16-bit register bus. The bus has a write strobe, a byte address and write data. Read data comes back combinationally from the address. Each channel has three registers: control, counter and compare. The address decode takes the channel index from the byte address divided by eight. Channel 0's registers are moved up by two bytes so that they follow the start register at address 0.

Top module: `dcm_timer`

## Requirements
- R1: After reset the start register, both control registers and both counters read 0, both compare registers read 0xFFFF, and both interrupt outputs are low.
- R2: The start register is at byte address 0, with bit n enabling channel n; its other bits read 0. Channel 0 control, counter and compare sit at 0x2, 0x4 and 0x6, and channel 1 at 0x8, 0xA and 0xC. Control keeps the clock select in bits [1:0] and the interrupt enable in bit 6, and all its other bits read 0.
- R3: A read from any other address (0xE or any odd address) returns 0xFFFF, and a write to such an address changes no register.
- R4: A running channel's counter advances once every 8 << (2*select) input cycles (8, 32, 128, 512). It counts 0, 1, … up to the compare value inclusive and then returns to 0. The first step comes one full division period after the start.
- R5: Writing a start bit that goes from 0 to 1 zeroes that channel's counter and restarts its divider. Writing 1 to a bit that is already set leaves the counter and the divider phase alone.
- R6: While its start bit is clear, a channel's counter holds its value and its interrupt stays low.
- R7: When a running channel steps from its compare value to 0 and its interrupt enable is set, its interrupt output is high for exactly the clock cycle that follows that step.
- R8: With the interrupt enable clear, a channel still wraps at its compare value but never raises its interrupt.
- R9: Writing the counter register loads the written value at once and restarts the divider, so the next step comes one full period after the write.
- R10: Changing the clock select of a running channel keeps the counter value. The divider period in progress finishes at the old ratio, and the new ratio applies from the next period on.
- R11: The two channels count, wrap and interrupt independently of each other.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Input clock shared by both channels |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | 4 | Byte address of the register |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for bus_addr, combinational |
| irq | output | 2 | Per-channel compare interrupt pulse |

## Verification
The bound checker watches the following on every cycle. A stopped channel's counter never moves unless software clears or loads it. A running counter only ever steps by one or falls back to zero. A start edge leaves the counter at zero. An interrupt is a lone single-cycle pulse that follows a wrap to zero and only occurs with its enable set. The exact spacing of the divided ticks for each select value, the wrap point set by the compare register, the address map and the 0xFFFF read of unused addresses can only be shown by the bench's scenarios. The same holds for the retained divider phase on a repeated start write, the phase restart on a counter load and the delayed effect of a select change.

// File: rtl/dcm_pkg.sv
`timescale 1ns/1ps
package dcm_pkg;

    localparam int CKS_W         = 2;
    localparam int DIV_BASE_LOG2 = 3;
    localparam int DIV_STEP_LOG2 = 2;
    localparam int PRE_W         = DIV_BASE_LOG2 + DIV_STEP_LOG2 * ((1 << CKS_W) - 1);
    localparam int REG_W         = 16;
    localparam int IE_BIT        = 6;
    localparam int CH_SPAN_LOG2  = 3;
    localparam int CH0_SHIFT     = 2;

    typedef struct packed {
        logic             ie;
        logic [CKS_W-1:0] cks;
    } ctrl_t;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_START,
        SEL_CTRL,
        SEL_CNT,
        SEL_CMP
    } reg_sel_e;

    function automatic logic [PRE_W-1:0] div_limit(input logic [CKS_W-1:0] cks);
        int unsigned sh;
        sh = DIV_BASE_LOG2 + DIV_STEP_LOG2 * int'(cks);
        return PRE_W'((32'd1 << sh) - 32'd1);
    endfunction

    function automatic logic [REG_W-1:0] ctrl_to_word(input ctrl_t c);
        logic [REG_W-1:0] w;
        w = '0;
        w[CKS_W-1:0] = c.cks;
        w[IE_BIT]    = c.ie;
        return w;
    endfunction

    function automatic ctrl_t word_to_ctrl(input logic [REG_W-1:0] w);
        ctrl_t c;
        c.cks = w[CKS_W-1:0];
        c.ie  = w[IE_BIT];
        return c;
    endfunction

endpackage

// File: rtl/dcm_prescaler.sv
`timescale 1ns/1ps
module dcm_prescaler
    import dcm_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic             clear,
    input  logic [CKS_W-1:0] sel,
    output logic             tick
);

    logic [PRE_W-1:0] phase_q;
    logic [CKS_W-1:0] sel_q;

    // The ratio in use is latched only at a period boundary or a restart.
    assign tick = en && !clear && (phase_q == div_limit(sel_q));

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= '0;
            sel_q   <= '0;
        end else if (clear) begin
            phase_q <= '0;
            sel_q   <= sel;
        end else if (tick) begin
            phase_q <= '0;
            sel_q   <= sel;
        end else if (en) begin
            phase_q <= phase_q + 1'b1;
        end
    end

endmodule

// File: rtl/dcm_channel.sv
`timescale 1ns/1ps
module dcm_channel
    import dcm_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic             restart,
    input  logic             ctrl_wr,
    input  logic             cnt_wr,
    input  logic             cmp_wr,
    input  logic [REG_W-1:0] wdata,
    output ctrl_t            ctrl_q,
    output logic [CNT_W-1:0] cnt_q,
    output logic [CNT_W-1:0] cmp_q,
    output logic             irq
);

    logic tick;
    logic phase_clr;
    logic at_cmp;

    assign phase_clr = restart | cnt_wr;
    assign at_cmp    = (cnt_q == cmp_q);

    dcm_prescaler u_pre (
        .clk   (clk),
        .rst   (rst),
        .en    (run),
        .clear (phase_clr),
        .sel   (ctrl_q.cks),
        .tick  (tick)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
            cmp_q  <= '1;
        end else begin
            if (ctrl_wr) ctrl_q <= word_to_ctrl(wdata);
            if (cmp_wr)  cmp_q  <= CNT_W'(wdata);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            irq   <= 1'b0;
        end else begin
            irq <= tick && at_cmp && ctrl_q.ie;
            if (restart) begin
                cnt_q <= '0;
            end else if (cnt_wr) begin
                cnt_q <= CNT_W'(wdata);
            end else if (tick) begin
                cnt_q <= at_cmp ? '0 : cnt_q + 1'b1;
            end
        end
    end

endmodule

// File: rtl/dcm_timer.sv
`timescale 1ns/1ps
module dcm_timer
    import dcm_pkg::*;
#(
    parameter int NUM_CH = 2,
    parameter int CNT_W  = 16,
    localparam int CH_W   = $clog2(NUM_CH),
    localparam int ADDR_W = CH_W + CH_SPAN_LOG2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [REG_W-1:0]  bus_wdata,
    output logic [REG_W-1:0]  bus_rdata,
    output logic [NUM_CH-1:0] irq
);

    reg_sel_e                     sel;
    logic [CH_W-1:0]              ch_idx;
    logic [CH_SPAN_LOG2-1:0]      off;
    logic [NUM_CH-1:0]            run_q;
    logic [NUM_CH-1:0]            start_pulse;
    logic [NUM_CH-1:0]            clr_vec;
    logic [NUM_CH-1:0]            ie_vec;
    logic [NUM_CH-1:0][CNT_W-1:0] cnt_vec;
    logic [NUM_CH-1:0][CNT_W-1:0] cmp_vec;
    ctrl_t [NUM_CH-1:0]           ctrl_vec;
    logic                         start_wr;

    // Address decode: channel from addr/8, channel 0 offsets moved by two bytes.
    always_comb begin
        ch_idx = bus_addr[ADDR_W-1:CH_SPAN_LOG2];
        off    = bus_addr[CH_SPAN_LOG2-1:0];
        sel    = SEL_NONE;
        if (bus_addr == '0) begin
            sel = SEL_START;
        end else if (int'(ch_idx) < NUM_CH) begin
            if (ch_idx == '0) off = off - CH_SPAN_LOG2'(CH0_SHIFT);
            case (off)
                3'd0:    sel = SEL_CTRL;
                3'd2:    sel = SEL_CNT;
                3'd4:    sel = SEL_CMP;
                default: sel = SEL_NONE;
            endcase
        end
    end

    assign start_wr = bus_wr && (sel == SEL_START);

    always_ff @(posedge clk) begin
        if (rst) run_q <= '0;
        else if (start_wr) run_q <= bus_wdata[NUM_CH-1:0];
    end

    generate
        for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
            logic hit;
            assign hit            = bus_wr && (ch_idx == CH_W'(i));
            assign start_pulse[i] = start_wr && bus_wdata[i] && !run_q[i];
            assign clr_vec[i]     = start_pulse[i] | (hit && sel == SEL_CNT);
            assign ie_vec[i]      = ctrl_vec[i].ie;

            dcm_channel #(.CNT_W(CNT_W)) u_ch (
                .clk     (clk),
                .rst     (rst),
                .run     (run_q[i]),
                .restart (start_pulse[i]),
                .ctrl_wr (hit && sel == SEL_CTRL),
                .cnt_wr  (hit && sel == SEL_CNT),
                .cmp_wr  (hit && sel == SEL_CMP),
                .wdata   (bus_wdata),
                .ctrl_q  (ctrl_vec[i]),
                .cnt_q   (cnt_vec[i]),
                .cmp_q   (cmp_vec[i]),
                .irq     (irq[i])
            );
        end
    endgenerate

    always_comb begin
        unique case (sel)
            SEL_START: bus_rdata = REG_W'(run_q);
            SEL_CTRL:  bus_rdata = ctrl_to_word(ctrl_vec[ch_idx]);
            SEL_CNT:   bus_rdata = REG_W'(cnt_vec[ch_idx]);
            SEL_CMP:   bus_rdata = REG_W'(cmp_vec[ch_idx]);
            default:   bus_rdata = '1;
        endcase
    end

endmodule

// File: rtl/dcm_timer_checker.sv
`timescale 1ns/1ps
module dcm_timer_checker #(
    parameter int NUM_CH = 2,
    parameter int CNT_W  = 16
) (
    input logic                         clk,
    input logic                         rst,
    input logic [NUM_CH-1:0]            run,
    input logic [NUM_CH-1:0]            clr,
    input logic [NUM_CH-1:0]            start,
    input logic [NUM_CH-1:0]            ctrl_ie,
    input logic [NUM_CH-1:0][CNT_W-1:0] cnt,
    input logic [NUM_CH-1:0][CNT_W-1:0] cmp,
    input logic [NUM_CH-1:0]            irq
);

    generate
        for (genvar i = 0; i < NUM_CH; i++) begin : g_chk
            assert_reset_state_R1: assert property (@(posedge clk) disable iff (rst)
                $past(rst) |-> (cnt[i] == '0 && cmp[i] == '1 && !run[i] && !ctrl_ie[i] && !irq[i]));

            assert_stopped_hold_R6: assert property (@(posedge clk) disable iff (rst)
                (!$past(run[i]) && !$past(clr[i])) |-> ($stable(cnt[i]) && !irq[i]));

            assert_count_step_R4: assert property (@(posedge clk) disable iff (rst)
                ($past(run[i]) && !$past(clr[i]) && cnt[i] != $past(cnt[i]))
                    |-> (cnt[i] == $past(cnt[i]) + 1'b1 || cnt[i] == '0));

            assert_start_zero_R5: assert property (@(posedge clk) disable iff (rst)
                $past(start[i]) |-> cnt[i] == '0);

            assert_irq_single_R7: assert property (@(posedge clk) disable iff (rst)
                irq[i] |=> !irq[i]);

            assert_irq_at_wrap_R7: assert property (@(posedge clk) disable iff (rst)
                irq[i] |-> (cnt[i] == '0 || $past(clr[i])));

            assert_irq_needs_ie_R8: assert property (@(posedge clk) disable iff (rst)
                irq[i] |-> $past(ctrl_ie[i]));
        end
    endgenerate

endmodule

bind dcm_timer dcm_timer_checker #(.NUM_CH(NUM_CH), .CNT_W(CNT_W)) u_dcm_chk (
    .clk     (clk),
    .rst     (rst),
    .run     (run_q),
    .clr     (clr_vec),
    .start   (start_pulse),
    .ctrl_ie (ie_vec),
    .cnt     (cnt_vec),
    .cmp     (cmp_vec),
    .irq     (irq)
);

// File: tb/dcm_timer_bench.sv
`timescale 1ns/1ps
module dcm_timer_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_wr = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic [1:0]  irq;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    dcm_timer u_dcm_timer (
        .clk       (clk),
        .rst       (rst),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq       (irq)
    );

    function automatic logic [3:0] a_of(input int ch, input int o);
        return 4'(ch * 8 + o + (ch == 0 ? 2 : 0));
    endfunction

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [15:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [15:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog actual=hung expected=finished");
            summary();
        end
    end

    initial begin
        logic [15:0] v;
        logic [15:0] snap;
        rst = 1'b1;
        wait_n(3);
        rst = 1'b0;
        wait_n(1);

        // R1: reset values
        rd(4'h0, v); check("R1 start", v, 16'h0000);
        for (int ch = 0; ch < 2; ch++) begin
            rd(a_of(ch, 0), v); check("R1 ctrl", v, 16'h0000);
            rd(a_of(ch, 2), v); check("R1 cnt", v, 16'h0000);
            rd(a_of(ch, 4), v); check("R1 cmp", v, 16'hFFFF);
        end
        check("R1 irq", {14'd0, irq}, 16'h0000);

        // R3: unused addresses read all ones, writes there are ignored
        rd(4'hE, v); check("R3 read 0xE", v, 16'hFFFF);
        rd(4'h1, v); check("R3 read odd", v, 16'hFFFF);
        rd(4'h9, v); check("R3 read odd ch1", v, 16'hFFFF);
        wr(4'hE, 16'h0000);
        wr(4'h7, 16'h1234);
        rd(a_of(0, 4), v); check("R3 cmp0 untouched", v, 16'hFFFF);
        rd(a_of(1, 4), v); check("R3 cmp1 untouched", v, 16'hFFFF);
        rd(a_of(1, 0), v); check("R3 ctrl1 untouched", v, 16'h0000);
        rd(4'h0, v); check("R3 start untouched", v, 16'h0000);

        // R2: field positions and read-back
        wr(a_of(1, 0), 16'hFFFF);
        rd(a_of(1, 0), v); check("R2 ctrl fields", v, 16'h0043);
        wr(a_of(1, 4), 16'hABCD);
        rd(a_of(1, 4), v); check("R2 cmp1 readback", v, 16'hABCD);
        rd(a_of(0, 4), v); check("R2 cmp0 separate", v, 16'hFFFF);
        wr(4'h0, 16'hFFFF);
        rd(4'h0, v); check("R2 start bits", v, 16'h0003);
        wr(4'h0, 16'h0000);
        wr(a_of(1, 0), 16'h0000);

        // R4/R7/R11: sweep every select on both channels
        for (int ch = 0; ch < 2; ch++) begin
            for (int cks = 0; cks < 4; cks++) begin
                int r;
                int c;
                int per;
                r = 8 << (2 * cks);
                c = (ch == 0) ? 2 : 1;
                per = (c + 1) * r;
                wr(4'h0, 16'h0000);
                wr(a_of(ch, 0), 16'(cks) | 16'h0040);
                wr(a_of(ch, 4), 16'(c));
                rd(a_of(1 - ch, 2), snap);
                wr(4'h0, 16'(1 << ch));
                for (int n = 0; n <= 2 * per; n++) begin
                    rd(a_of(ch, 2), v);
                    check("R4 count value", v, 16'((n / r) % (c + 1)));
                    check("R7 irq pulse", {15'd0, irq[ch]},
                          16'((n > 0 && n % per == 0) ? 1 : 0));
                    check("R11 other irq quiet", {15'd0, irq[1 - ch]}, 16'h0000);
                    @(negedge clk);
                end
                rd(a_of(1 - ch, 2), v); check("R11 other cnt held", v, snap);
            end
        end
        wr(4'h0, 16'h0000);

        // R8: no interrupt with enable clear, counter still wraps
        wr(a_of(0, 0), 16'h0000);
        wr(a_of(0, 4), 16'h0001);
        wr(4'h0, 16'h0001);
        for (int n = 0; n <= 40; n++) begin
            check("R8 irq off", {14'd0, irq}, 16'h0000);
            if (n == 16) begin
                rd(a_of(0, 2), v); check("R8 wrap without irq", v, 16'h0000);
            end
            @(negedge clk);
        end
        wr(4'h0, 16'h0000);

        // R5: start restart and repeated start write
        wr(a_of(0, 4), 16'hFFFF);
        wr(4'h0, 16'h0001);
        wait_n(20);
        rd(a_of(0, 2), v); check("R5 before rewrite", v, 16'd2);
        wr(4'h0, 16'h0001);
        rd(a_of(0, 2), v); check("R5 rewrite keeps count", v, 16'd2);
        wait_n(3);
        rd(a_of(0, 2), v); check("R5 rewrite keeps phase", v, 16'd3);

        // R9: counter load restarts the phase (now n=24 from start)
        wr(a_of(0, 2), 16'h0100);
        rd(a_of(0, 2), v); check("R9 load", v, 16'h0100);
        wait_n(7);
        rd(a_of(0, 2), v); check("R9 full period before step", v, 16'h0100);
        wait_n(1);
        rd(a_of(0, 2), v); check("R9 step after period", v, 16'h0101);

        // R6: stop holds the count; R5: restart clears it
        wr(a_of(0, 4), 16'h0003);
        wr(a_of(0, 0), 16'h0040);
        wr(4'h0, 16'h0000);
        rd(a_of(0, 2), snap);
        for (int n = 0; n < 100; n++) begin
            check("R6 no irq stopped", {14'd0, irq}, 16'h0000);
            @(negedge clk);
        end
        rd(a_of(0, 2), v); check("R6 count held", v, snap);
        wr(4'h0, 16'h0001);
        rd(a_of(0, 2), v); check("R5 start zeroes", v, 16'h0000);
        wr(4'h0, 16'h0000);

        // R10: select change applies from next period
        wr(a_of(0, 0), 16'h0000);
        wr(a_of(0, 4), 16'hFFFF);
        wr(4'h0, 16'h0001);
        wait_n(3);
        wr(a_of(0, 0), 16'h0001);
        rd(a_of(0, 2), v); check("R10 count kept", v, 16'd0);
        rd(a_of(0, 0), v); check("R10 ctrl readback", v, 16'h0001);
        wait_n(4);
        rd(a_of(0, 2), v); check("R10 old ratio finishes", v, 16'd1);
        wait_n(31);
        rd(a_of(0, 2), v); check("R10 new ratio wait", v, 16'd1);
        wait_n(1);
        rd(a_of(0, 2), v); check("R10 new ratio step", v, 16'd2);
        wr(4'h0, 16'h0000);

        done = 1'b1;
        summary();
    end

endmodule